// File: doc/BRIEF.md
# Pretrigger Function Event Counters

This block keeps a running tally of decoded pretrigger function events for one monitored channel. An upstream decoder turns the serial pretrigger line into single-cycle strobes. There is one strobe for each recognised function code (1 to 7) and one for a code it could not recognise. Code 0 means "no function" and has no strobe, so it is never counted. The function codes are: 1 pretrigger, 2 clear, 3 reserved, 4 low-power mode, 5 acquisition mode, 6 test mode, and 7 start test pulse.

Each strobe drives its own 4-bit counter. Each counter stops at 15 instead of wrapping, so an overflow stays visible. All eight counters are packed into one 32-bit read word. The read word is driven combinationally from the counter registers, so a bus read returns the counts with no added latency.

A synchronous clear input, driven by a bus write to the counter offsets, zeroes every count. An asynchronous active-low reset also zeroes every count. Four instances of this block cover four channels.

Top module: `pretrig_evt_counters`

## Requirements
- R1: While `rst_n` is low, every count is forced to zero without waiting for a clock edge, and `rd_word` reads 0.
- R2: A high `evt_stb[k]` at a rising edge raises slot k's count by one at that edge. Slot 0 is the unknown-code counter and slot k (1..7) is function code k. Slot k occupies `rd_word` bits 4k+3..4k, so code 7 sits in bits 31..28 and the unknown counter in bits 3..0.
- R3: A count that has reached 15 stays at 15 on further strobes and never wraps to 0.
- R4: A high `clr` at a rising edge zeroes all eight counts at that edge. This holds even when strobes are high in the same cycle: the clear wins.
- R5: Strobes on several slots in the same cycle each advance their own count independently.
- R6: With `clr` low and no strobe high, every count keeps its value.
- R7: `rd_word` follows the counter registers combinationally. A count that changes at an edge is visible on `rd_word` in the same clock cycle, before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counts, from a bus write |
| evt_stb | input | 8 | Event strobes; bit 0 is the unknown code, bit k is function code k |
| rd_word | output | 32 | Packed counts, slot k in bits 4k+3..4k |

## Verification
The embedded assertions check four behaviours on every cycle for each counter cell:
- the single-step increment;
- holding at 15;
- clear priority over strobes;
- holding when idle.

At the top level, they also check that a clear empties the whole word and that an idle cycle leaves it unchanged.

Some behaviours only the bench's scenarios can show. These are the field placement of each slot inside the read word, the asynchronous reset taking effect between clock edges, and the same-cycle visibility of a new count on `rd_word`. The bench shows them by comparing the word against a behavioural model after every edge.

// File: rtl/pretrig_cnt_pkg.sv
package pretrig_cnt_pkg;

    // Default geometry: seven function codes plus one unknown slot
    localparam int DEF_CNT_W     = 4;
    localparam int DEF_NUM_SLOTS = 8;

    // Lowest bit of a slot's field inside the packed read word
    function automatic int slot_lsb(input int slot, input int cnt_w);
        return slot * cnt_w;
    endfunction

endpackage

// File: rtl/sat_cnt.sv
module sat_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;
    logic             at_max;

    assign at_max = (cnt == CMAX);

    // Next-count selection: clear first, then saturating increment
    always_comb begin
        cnt_nxt = cnt;
        if (clr) begin
            cnt_nxt = '0;
        end else if (inc && !at_max) begin
            cnt_nxt = cnt + ONE;
        end
    end

    // Count register with asynchronous reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    // R2: one step per strobe below the ceiling
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !at_max) |=> (cnt == $past(cnt) + ONE));

    // R3: the ceiling holds
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clr) |=> (cnt == CMAX));

    // R4: clear beats any strobe
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R6: idle keeps the value
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(cnt));

endmodule

// File: rtl/slot_bank.sv
module slot_bank
    import pretrig_cnt_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic [NUM_SLOTS-1:0]       stb,
    output logic [NUM_SLOTS*CNT_W-1:0] packed_cnt
);

    // One saturating counter per slot, placed at its fixed field
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int LSB = slot_lsb(s, CNT_W);

        sat_cnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (stb[s]),
            .cnt   (packed_cnt[LSB +: CNT_W])
        );
    end

endmodule

// File: rtl/pretrig_evt_counters.sv
module pretrig_evt_counters
    import pretrig_cnt_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic [NUM_SLOTS-1:0]       evt_stb,
    output logic [NUM_SLOTS*CNT_W-1:0] rd_word
);

    localparam int WORD_W = NUM_SLOTS * CNT_W;

    logic [WORD_W-1:0] bank_word;

    slot_bank #(
        .CNT_W     (CNT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .stb        (evt_stb),
        .packed_cnt (bank_word)
    );

    // R7: read path is wiring only, no register stage
    assign rd_word = bank_word;

    // R4: a clear empties the whole word
    a_r4_word_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_word == '0));

    // R6: no clear and no strobe leaves the word untouched
    a_r6_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (evt_stb == '0)) |=> $stable(rd_word));

endmodule

// File: tb/pretrig_evt_counters_tb.sv
module pretrig_evt_counters_tb;

    localparam int NS = 8;
    localparam int CW = 4;
    localparam int WDOG_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [NS-1:0] evt_stb = '0;
    logic [31:0]   rd_word;

    int ref_cnt [NS];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pretrig_evt_counters u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .evt_stb (evt_stb),
        .rd_word (rd_word)
    );

    // Behavioural reference: integer tallies, clear first, cap at 15
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) ref_cnt[i] = 0;
        end else if (clr) begin
            for (int i = 0; i < NS; i++) ref_cnt[i] = 0;
        end else begin
            for (int i = 0; i < NS; i++)
                if (evt_stb[i] && ref_cnt[i] < 15) ref_cnt[i] = ref_cnt[i] + 1;
        end
    end

    function automatic logic [31:0] ref_word();
        logic [31:0] w = '0;
        for (int i = 0; i < NS; i++) w[i*CW +: CW] = 4'(ref_cnt[i]);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_word actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: compare at falling edge, then apply new inputs
    task automatic step(input string tag, input logic c, input logic [NS-1:0] s);
        @(negedge clk);
        chk(tag, rd_word, ref_word());
        clr     = c;
        evt_stb = s;
    endtask

    initial begin
        #1;
        chk("R1 reset asserted", rd_word, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 after reset", 1'b0, '0);

        // R2: walk one strobe across every slot, checking field placement
        for (int k = 0; k < NS; k++) begin
            for (int r = 0; r <= k; r++) step("R2 single slot", 1'b0, NS'(1) << k);
        end
        step("R2 single slot", 1'b0, '0);
        step("R2 field placement", 1'b0, '0);
        chk("R2 field placement", rd_word, 32'h8765_4321);

        // R6: idle cycles hold
        repeat (4) step("R6 idle hold", 1'b0, '0);

        // R5: several slots together
        repeat (3) step("R5 multi slot", 1'b0, 8'b1010_0101);
        step("R5 multi slot", 1'b0, 8'hFF);
        step("R5 multi slot", 1'b0, '0);

        // R3: push slot 3 well past 15
        repeat (20) step("R3 saturate", 1'b0, 8'b0000_1000);
        step("R3 saturate", 1'b0, '0);
        step("R3 saturate", 1'b0, '0);
        chk("R3 held at 15", rd_word[15:12], 4'hF);

        // R4: clear together with every strobe
        step("R4 clear wins", 1'b1, 8'hFF);
        step("R4 clear wins", 1'b0, '0);
        chk("R4 zero after clear", rd_word, 32'h0);

        // R7: mixed random traffic, count visible in the cycle after the edge
        for (int i = 0; i < 300; i++)
            step("R7 random mix", ($urandom_range(0, 19) == 0), NS'($urandom));
        repeat (40) step("R3 random saturate", 1'b0, 8'hFF);
        step("R3 all at 15", 1'b0, '0);
        chk("R3 all at 15", rd_word, 32'hFFFF_FFFF);

        // R1: asynchronous reset between edges
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1 chk("R1 async reset", rd_word, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 after async reset", 1'b0, 8'h01);
        step("R7 after async reset", 1'b0, '0);
        step("R7 after async reset", 1'b0, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule